// File: doc/BRIEF.md
# Return-From-Exception Load Sequencer

This block carries out the memory side of a return from an exception handler on a 32-bit processor model. A decoded request supplies a base register index and its value, the stacking direction, the word-select choice, a writeback request and the current privilege level. The block computes the address of a two-word frame and reads the frame through a read port that uses valid/ready handshakes, lower address first. The lower word becomes the new program counter and the upper word becomes the restored status word. Both values leave the block together in a single completion cycle. The same cycle can also carry an updated base register value.

The request arrives in one of two encodings. The full-width encoding carries separate up/down and before/after bits, which give four stacking modes. The compact encoding carries a two-bit opcode that fixes the mode. Some requests are refused before any memory traffic takes place. These are a request that uses the program-counter register as its base, a compact request issued from a non-final slot of a conditional block, a request made at privilege level 2, and a request made at privilege level 0. Each refusal ends in a one-cycle indication. A read error on either word aborts the sequence.

Top module: `exc_return_seq`

## Requirements
- R1: For full-width requests the first read address depends on `req_up` and `req_pre`. It is the base when `req_up`=1 and the base minus 8 when `req_up`=0. When `req_pre` equals `req_up`, 4 is added to that address. The four modes therefore read first from base-4 (up=0, pre=0), base-8 (up=0, pre=1), base (up=1, pre=0) and base+4 (up=1, pre=1).
- R2: Exactly two reads are issued. The second read's address is the first plus 4. The second read is not requested until the response to the first has been received.
- R3: On success, `ret_done` is high for exactly one cycle, one cycle after the second response is accepted. In that cycle `ret_pc` holds the first word read and `ret_status` holds the second.
- R4: `wb_en` is high only in the `ret_done` cycle, and only if `req_wb` was set. In that cycle `wb_idx` holds the base index and `wb_val` holds the original base plus 8 (`req_up`=1) or minus 8 (`req_up`=0). The read address has no effect on `wb_val`.
- R5: A request at privilege level 2 (`req_priv`=2'b10) produces a one-cycle `ret_undef` pulse in the cycle after acceptance and issues no read.
- R6: A request at privilege level 0 (`req_priv`=2'b00) produces a one-cycle pulse in the cycle after acceptance and issues no read. The pulse is on `ret_undef` when parameter `LVL0_UNDEF`=1 and on `ret_nop` when it is 0.
- R7: A base index of 15 produces a one-cycle `ret_unpred` pulse and no read. This check takes priority over the privilege checks.
- R8: For compact requests (`req_compact`=1), opcode 2'b00 reads first from base-8 and writes back base-8. Opcode 2'b11 reads first from base and writes back base+8. Opcodes 2'b01 and 2'b10 are reported on `ret_unpred`.
- R9: A compact request with `req_in_blk`=1 and `req_last_in_blk`=0 is reported on `ret_unpred` and issues no read.
- R10: A response with `mem_rsp_err`=1 on either read ends the sequence with a one-cycle `ret_abort` pulse. No `ret_done` and no `wb_en` are produced, and no further read is issued.
- R11: `req_ready` is high only while the block is idle. Synchronous reset makes the block idle with every pulse output, `wb_en` and `mem_rd_valid` low.
- R12: While `mem_rd_valid` is high and `mem_rd_ready` is low, the request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_compact | input | 1 | 1 selects the compact encoding |
| req_up | input | 1 | Full-width: 1 ascends through memory |
| req_pre | input | 1 | Full-width: before/after bit |
| req_op | input | 2 | Compact opcode |
| req_in_blk | input | 1 | Compact request sits in a conditional block |
| req_last_in_blk | input | 1 | It is the final slot of that block |
| req_base_idx | input | 4 | Base register index |
| req_base_val | input | 32 | Base register value |
| req_wb | input | 1 | Write updated base back |
| req_priv | input | 2 | Current privilege level |
| mem_rd_valid | output | 1 | Read request |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 32 | Read response word |
| mem_rsp_err | input | 1 | Read response is an error |
| ret_done | output | 1 | Successful completion pulse |
| ret_abort | output | 1 | Read error pulse |
| ret_undef | output | 1 | Undefined-instruction pulse |
| ret_nop | output | 1 | Request ignored pulse |
| ret_unpred | output | 1 | Unpredictable-request pulse |
| ret_pc | output | 32 | New program counter |
| ret_status | output | 32 | Restored status word |
| wb_en | output | 1 | Base writeback strobe |
| wb_idx | output | 4 | Writeback register index |
| wb_val | output | 32 | Writeback value |

## Verification
The hardest case to reach is an error on the second read after the first word has already been captured. The sequence must then drop the stored program counter and the pending writeback without producing a completion. The memory responder in the bench counts handshakes and can be told to return an error on a chosen read number, so a writeback-enabled request can be made to fail on its second read. A second case is a long stall on the read request. The responder holds back `mem_rd_ready` for several cycles and compares the address in every stalled cycle with the address it first saw.

// File: rtl/exc_return_pkg.sv
package exc_return_pkg;

    typedef enum logic [1:0] {
        LVL0 = 2'b00,
        LVL1 = 2'b01,
        LVL2 = 2'b10,
        LVL3 = 2'b11
    } priv_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_WT_LO,
        ST_RD_HI,
        ST_WT_HI
    } seq_state_e;

    typedef enum logic [1:0] {
        V_RUN,
        V_UNDEF,
        V_NOP,
        V_UNPRED
    } verdict_e;

    // Stacking walk: direction and whether the frame starts one word up
    typedef struct packed {
        logic up;
        logic hi_word;
    } walk_t;

    localparam logic [1:0] CMP_DOWN_BEFORE = 2'b00;
    localparam logic [1:0] CMP_UP_AFTER    = 2'b11;

    function automatic walk_t full_walk(input logic up, input logic pre);
        walk_t w;
        w.up      = up;
        w.hi_word = (pre == up);
        return w;
    endfunction

    function automatic walk_t compact_walk(input logic [1:0] op);
        walk_t w;
        w.up      = (op == CMP_UP_AFTER);
        w.hi_word = 1'b0;
        return w;
    endfunction

endpackage

// File: rtl/exc_return_decode.sv
module exc_return_decode
    import exc_return_pkg::*;
#(
    parameter int IDX_W      = 4,
    parameter bit LVL0_UNDEF = 1'b0
) (
    input  logic             compact,
    input  logic             up,
    input  logic             pre,
    input  logic [1:0]       op,
    input  logic             in_blk,
    input  logic             last_in_blk,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       priv,
    output walk_t            walk,
    output verdict_e         verdict
);
    localparam logic [IDX_W-1:0] PC_INDEX = '1;

    logic op_legal;
    logic unpred;

    assign op_legal = (op == CMP_DOWN_BEFORE) || (op == CMP_UP_AFTER);
    assign walk     = compact ? compact_walk(op) : full_walk(up, pre);

    always_comb begin
        unpred = (idx == PC_INDEX);
        if (compact && (!op_legal || (in_blk && !last_in_blk))) begin
            unpred = 1'b1;
        end
    end

    // Encoding checks first, then the privilege level
    always_comb begin
        if (unpred) begin
            verdict = V_UNPRED;
        end else if (priv == LVL2) begin
            verdict = V_UNDEF;
        end else if (priv == LVL0) begin
            verdict = LVL0_UNDEF ? V_UNDEF : V_NOP;
        end else begin
            verdict = V_RUN;
        end
    end
endmodule

// File: rtl/exc_return_addr.sv
module exc_return_addr
    import exc_return_pkg::*;
#(
    parameter int DW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic [DW-1:0] base,
    input  walk_t         walk,
    output logic [DW-1:0] lo_addr,
    output logic [DW-1:0] hi_addr,
    output logic [DW-1:0] wb_val
);
    localparam logic [DW-1:0] WORD = DW'(WORD_BYTES);
    localparam logic [DW-1:0] PAIR = DW'(2 * WORD_BYTES);

    logic [DW-1:0] floor_addr;

    assign floor_addr = walk.up ? base : base - PAIR;
    assign lo_addr    = walk.hi_word ? floor_addr + WORD : floor_addr;
    assign hi_addr    = lo_addr + WORD;
    assign wb_val     = walk.up ? base + PAIR : base - PAIR;
endmodule

// File: rtl/exc_return_seq.sv
module exc_return_seq
    import exc_return_pkg::*;
#(
    parameter int DW         = 32,
    parameter int IDX_W      = 4,
    parameter int WORD_BYTES = 4,
    parameter bit LVL0_UNDEF = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_compact,
    input  logic             req_up,
    input  logic             req_pre,
    input  logic [1:0]       req_op,
    input  logic             req_in_blk,
    input  logic             req_last_in_blk,
    input  logic [IDX_W-1:0] req_base_idx,
    input  logic [DW-1:0]    req_base_val,
    input  logic             req_wb,
    input  logic [1:0]       req_priv,
    output logic             mem_rd_valid,
    input  logic             mem_rd_ready,
    output logic [DW-1:0]    mem_rd_addr,
    input  logic             mem_rsp_valid,
    input  logic [DW-1:0]    mem_rsp_data,
    input  logic             mem_rsp_err,
    output logic             ret_done,
    output logic             ret_abort,
    output logic             ret_undef,
    output logic             ret_nop,
    output logic             ret_unpred,
    output logic [DW-1:0]    ret_pc,
    output logic [DW-1:0]    ret_status,
    output logic             wb_en,
    output logic [IDX_W-1:0] wb_idx,
    output logic [DW-1:0]    wb_val
);
    seq_state_e       state;
    walk_t            dec_walk;
    verdict_e         dec_verdict;
    walk_t            walk_q;
    logic [DW-1:0]    base_q;
    logic [IDX_W-1:0] idx_q;
    logic             wb_q;
    logic [DW-1:0]    lo_word;
    logic [DW-1:0]    lo_addr;
    logic [DW-1:0]    hi_addr;
    logic [DW-1:0]    wb_calc;

    exc_return_decode #(
        .IDX_W      (IDX_W),
        .LVL0_UNDEF (LVL0_UNDEF)
    ) u_decode (
        .compact     (req_compact),
        .up          (req_up),
        .pre         (req_pre),
        .op          (req_op),
        .in_blk      (req_in_blk),
        .last_in_blk (req_last_in_blk),
        .idx         (req_base_idx),
        .priv        (req_priv),
        .walk        (dec_walk),
        .verdict     (dec_verdict)
    );

    exc_return_addr #(
        .DW         (DW),
        .WORD_BYTES (WORD_BYTES)
    ) u_addr (
        .base    (base_q),
        .walk    (walk_q),
        .lo_addr (lo_addr),
        .hi_addr (hi_addr),
        .wb_val  (wb_calc)
    );

    assign req_ready    = (state == ST_IDLE);
    assign mem_rd_valid = (state == ST_RD_LO) || (state == ST_RD_HI);
    assign mem_rd_addr  = (state == ST_RD_HI) ? hi_addr : lo_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            walk_q     <= '0;
            base_q     <= '0;
            idx_q      <= '0;
            wb_q       <= 1'b0;
            lo_word    <= '0;
            ret_done   <= 1'b0;
            ret_abort  <= 1'b0;
            ret_undef  <= 1'b0;
            ret_nop    <= 1'b0;
            ret_unpred <= 1'b0;
            ret_pc     <= '0;
            ret_status <= '0;
            wb_en      <= 1'b0;
            wb_idx     <= '0;
            wb_val     <= '0;
        end else begin
            ret_done   <= 1'b0;
            ret_abort  <= 1'b0;
            ret_undef  <= 1'b0;
            ret_nop    <= 1'b0;
            ret_unpred <= 1'b0;
            wb_en      <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        case (dec_verdict)
                            V_RUN: begin
                                base_q <= req_base_val;
                                walk_q <= dec_walk;
                                idx_q  <= req_base_idx;
                                wb_q   <= req_wb;
                                state  <= ST_RD_LO;
                            end
                            V_UNDEF: ret_undef  <= 1'b1;
                            V_NOP:   ret_nop    <= 1'b1;
                            default: ret_unpred <= 1'b1;
                        endcase
                    end
                end
                ST_RD_LO: begin
                    if (mem_rd_ready) state <= ST_WT_LO;
                end
                ST_WT_LO: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            ret_abort <= 1'b1;
                            state     <= ST_IDLE;
                        end else begin
                            lo_word <= mem_rsp_data;
                            state   <= ST_RD_HI;
                        end
                    end
                end
                ST_RD_HI: begin
                    if (mem_rd_ready) state <= ST_WT_HI;
                end
                ST_WT_HI: begin
                    if (mem_rsp_valid) begin
                        state <= ST_IDLE;
                        if (mem_rsp_err) begin
                            ret_abort <= 1'b1;
                        end else begin
                            ret_done   <= 1'b1;
                            ret_pc     <= lo_word;
                            ret_status <= mem_rsp_data;
                            wb_en      <= wb_q;
                            wb_idx     <= idx_q;
                            wb_val     <= wb_calc;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/exc_return_seq_chk.sv
module exc_return_seq_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          mem_rd_valid,
    input logic          mem_rd_ready,
    input logic [DW-1:0] mem_rd_addr,
    input logic          ret_done,
    input logic          ret_abort,
    input logic          ret_undef,
    input logic          ret_nop,
    input logic          ret_unpred,
    input logic          wb_en
);
    // R10: at most one outcome per cycle (abort never with done)
    p_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ret_done, ret_abort, ret_undef, ret_nop, ret_unpred}));

    // R4: writeback strobe only alongside completion
    p_wb_with_done_r4: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> ret_done);

    // R3: completion lasts one cycle
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        ret_done |=> !ret_done);

    // R11: no read traffic while a request can be taken
    p_idle_no_read_r11: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_rd_valid);

    // R12: stalled read holds its address
    p_rd_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R5: refusals happen without a read in flight
    p_reject_no_read_r5: assert property (@(posedge clk) disable iff (rst)
        (ret_undef || ret_nop || ret_unpred) |-> !mem_rd_valid);
endmodule

bind exc_return_seq exc_return_seq_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .ret_done     (ret_done),
    .ret_abort    (ret_abort),
    .ret_undef    (ret_undef),
    .ret_nop      (ret_nop),
    .ret_unpred   (ret_unpred),
    .wb_en        (wb_en)
);

// File: tb/test_exc_return_seq.sv
module test_exc_return_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_valid_u;
    logic        req_ready, req_ready_u;
    logic        req_compact, req_up, req_pre;
    logic [1:0]  req_op;
    logic        req_in_blk, req_last_in_blk;
    logic [3:0]  req_base_idx;
    logic [31:0] req_base_val;
    logic        req_wb;
    logic [1:0]  req_priv;
    logic        mem_rd_valid, mem_rd_ready;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid, mem_rsp_err;
    logic [31:0] mem_rsp_data;
    logic        ret_done, ret_abort, ret_undef, ret_nop, ret_unpred;
    logic [31:0] ret_pc, ret_status, wb_val;
    logic        wb_en;
    logic [3:0]  wb_idx;
    // second instance, level-0 requests treated as undefined
    logic        u_rd_valid, u_done, u_abort, u_undef, u_nop, u_unpred, u_wb_en;
    logic [31:0] u_rd_addr, u_pc, u_status, u_wb_val;
    logic [3:0]  u_wb_idx;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int err_at = 0;
    int rd_gap = 0;
    int rsp_gap = 0;
    bit hold_bad = 0;
    logic [31:0] rd_log [4];
    int oc;
    logic rdy_after;

    always #5 clk = ~clk;

    exc_return_seq i_exc_return_seq (
        .clk, .rst, .req_valid, .req_ready, .req_compact, .req_up, .req_pre,
        .req_op, .req_in_blk, .req_last_in_blk, .req_base_idx, .req_base_val,
        .req_wb, .req_priv, .mem_rd_valid, .mem_rd_ready, .mem_rd_addr,
        .mem_rsp_valid, .mem_rsp_data, .mem_rsp_err, .ret_done, .ret_abort,
        .ret_undef, .ret_nop, .ret_unpred, .ret_pc, .ret_status, .wb_en,
        .wb_idx, .wb_val
    );

    exc_return_seq #(.LVL0_UNDEF(1'b1)) i_exc_return_seq_u (
        .clk, .rst, .req_valid(req_valid_u), .req_ready(req_ready_u),
        .req_compact, .req_up, .req_pre, .req_op, .req_in_blk,
        .req_last_in_blk, .req_base_idx, .req_base_val, .req_wb, .req_priv,
        .mem_rd_valid(u_rd_valid), .mem_rd_ready(1'b0), .mem_rd_addr(u_rd_addr),
        .mem_rsp_valid(1'b0), .mem_rsp_data(32'h0), .mem_rsp_err(1'b0),
        .ret_done(u_done), .ret_abort(u_abort), .ret_undef(u_undef),
        .ret_nop(u_nop), .ret_unpred(u_unpred), .ret_pc(u_pc),
        .ret_status(u_status), .wb_en(u_wb_en), .wb_idx(u_wb_idx),
        .wb_val(u_wb_val)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A5A_C3C3;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Memory responder
    initial begin
        logic [31:0] first;
        mem_rd_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0; mem_rsp_err = 0;
        forever begin
            @(negedge clk);
            if (mem_rd_valid) begin
                first = mem_rd_addr;
                for (int g = 0; g < rd_gap; g++) begin
                    @(negedge clk);
                    if (!mem_rd_valid || mem_rd_addr != first) hold_bad = 1;
                end
                mem_rd_ready = 1;
                @(negedge clk);
                mem_rd_ready = 0;
                if (rd_cnt < 4) rd_log[rd_cnt] = first;
                rd_cnt++;
                for (int g = 0; g < rsp_gap; g++) @(negedge clk);
                mem_rsp_valid = 1;
                mem_rsp_err   = (rd_cnt == err_at);
                mem_rsp_data  = mem_word(first);
                @(negedge clk);
                mem_rsp_valid = 0;
                mem_rsp_err   = 0;
            end
        end
    end

    // Issue one request at a negedge and wait for its outcome pulse
    task automatic issue(input bit cmp, input bit up, input bit pre,
                         input logic [1:0] op, input bit inb, input bit last,
                         input logic [3:0] idx, input logic [31:0] base,
                         input bit wb, input logic [1:0] priv);
        rd_cnt = 0; hold_bad = 0; oc = 0;
        req_compact = cmp; req_up = up; req_pre = pre; req_op = op;
        req_in_blk = inb; req_last_in_blk = last; req_base_idx = idx;
        req_base_val = base; req_wb = wb; req_priv = priv; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        rdy_after = req_ready;
        for (int k = 0; k < 80; k++) begin
            if (ret_done)        oc = 1;
            else if (ret_abort)  oc = 2;
            else if (ret_undef)  oc = 3;
            else if (ret_nop)    oc = 4;
            else if (ret_unpred) oc = 5;
            if (oc != 0) break;
            @(negedge clk);
        end
    endtask

    task automatic expect_run(input bit up, input logic [31:0] lo,
                              input logic [31:0] base, input bit wb,
                              input logic [3:0] idx, input string tag);
        logic [31:0] wbx;
        wbx = up ? base + 8 : base - 8;
        chk(oc == 1, {tag, " R3 done"}, oc, 1);
        chk(rdy_after == 0, {tag, " R11 busy not ready"}, rdy_after, 0);
        chk(rd_cnt == 2, {tag, " R2 two reads"}, rd_cnt, 2);
        chk(rd_log[0] == lo, {tag, " R1 first addr"}, rd_log[0], lo);
        chk(rd_log[1] == lo + 4, {tag, " R2 second addr"}, rd_log[1], lo + 4);
        chk(ret_pc == mem_word(lo), {tag, " R3 pc"}, ret_pc, mem_word(lo));
        chk(ret_status == mem_word(lo + 4), {tag, " R3 status"}, ret_status,
            mem_word(lo + 4));
        chk(wb_en == wb, {tag, " R4 wb_en"}, wb_en, wb);
        if (wb) begin
            chk(wb_val == wbx, {tag, " R4 wb_val"}, wb_val, wbx);
            chk(wb_idx == idx, {tag, " R4 wb_idx"}, wb_idx, idx);
        end
        @(negedge clk);
        chk(ret_done == 0, {tag, " R3 done one cycle"}, ret_done, 0);
        chk(hold_bad == 0, {tag, " R12 stalled addr stable"}, hold_bad, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_full(input bit up, input bit pre, input logic [31:0] base,
                          input bit wb, input int rg, input int sg,
                          input string tag);
        logic [31:0] lo;
        lo = (up ? base : base - 8) + ((pre == up) ? 32'd4 : 32'd0);
        rd_gap = rg; rsp_gap = sg; err_at = 0;
        issue(0, up, pre, 2'b00, 0, 0, 4'd5, base, wb, 2'b01);
        expect_run(up, lo, base, wb, 4'd5, tag);
    endtask

    task automatic t_compact(input logic [1:0] op, input bit inb, input bit last,
                             input logic [31:0] base, input string tag);
        bit up;
        up = (op == 2'b11);
        rd_gap = 1; rsp_gap = 0; err_at = 0;
        issue(1, 0, 0, op, inb, last, 4'd9, base, 1, 2'b11);
        expect_run(up, up ? base : base - 8, base, 1, 4'd9, tag);
    endtask

    task automatic t_reject(input bit cmp, input logic [1:0] op, input bit inb,
                            input bit last, input logic [3:0] idx,
                            input logic [1:0] priv, input int exp_oc,
                            input string tag);
        rd_gap = 0; rsp_gap = 0; err_at = 0;
        issue(cmp, 1, 0, op, inb, last, idx, 32'h0000_4000, 1, priv);
        chk(oc == exp_oc, {tag, " outcome"}, oc, exp_oc);
        repeat (4) @(negedge clk);
        chk(rd_cnt == 0, {tag, " no read"}, rd_cnt, 0);
        chk(wb_en == 0 && ret_done == 0, {tag, " no completion"}, wb_en, 0);
    endtask

    task automatic t_error(input int at, input string tag);
        rd_gap = 0; rsp_gap = 2; err_at = at;
        issue(0, 1, 1, 2'b00, 0, 0, 4'd2, 32'h0001_0000, 1, 2'b01);
        chk(oc == 2, {tag, " R10 abort"}, oc, 2);
        chk(wb_en == 0, {tag, " R10 no wb"}, wb_en, 0);
        repeat (5) @(negedge clk);
        chk(rd_cnt == at, {tag, " R10 reads stop"}, rd_cnt, at);
        chk(ret_done == 0, {tag, " R10 no done"}, ret_done, 0);
        err_at = 0;
    endtask

    task automatic t_lvl0_undef();
        int seen;
        seen = 0;
        req_compact = 0; req_up = 1; req_pre = 0; req_op = 0; req_in_blk = 0;
        req_last_in_blk = 0; req_base_idx = 4'd1; req_base_val = 32'h100;
        req_wb = 1; req_priv = 2'b00; req_valid_u = 1;
        @(negedge clk);
        req_valid_u = 0;
        chk(u_undef == 1, "R6 level0 undef variant", u_undef, 1);
        chk(u_nop == 0, "R6 level0 undef variant no nop", u_nop, 0);
        for (int k = 0; k < 4; k++) begin
            if (u_rd_valid) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R6 level0 undef variant no read", seen, 0);
    endtask

    initial begin
        bit to;
        to = 0;
        fork
            begin
                rst = 1; req_valid = 0; req_valid_u = 0; req_compact = 0;
                req_up = 0; req_pre = 0; req_op = 0; req_in_blk = 0;
                req_last_in_blk = 0; req_base_idx = 0; req_base_val = 0;
                req_wb = 0; req_priv = 2'b01;
                repeat (3) @(negedge clk);
                rst = 0;
                @(negedge clk);
                // R11 reset state
                chk(req_ready == 1, "R11 reset ready", req_ready, 1);
                chk(mem_rd_valid == 0, "R11 reset no read", mem_rd_valid, 0);
                chk({ret_done, ret_abort, ret_undef, ret_nop, ret_unpred, wb_en} == 0,
                    "R11 reset pulses low",
                    {ret_done, ret_abort, ret_undef, ret_nop, ret_unpred, wb_en}, 0);
                t_full(0, 0, 32'h0000_2000, 1, 0, 0, "R1 down-after");
                t_full(0, 1, 32'h0000_2100, 1, 3, 1, "R1 down-before");
                t_full(1, 0, 32'h0000_2200, 0, 0, 3, "R1 up-after");
                t_full(1, 1, 32'h8000_0000, 1, 4, 2, "R1 up-before");
                t_full(0, 0, 32'h0000_0004, 1, 1, 0, "R4 wrap below zero");
                t_compact(2'b00, 0, 0, 32'h0000_3000, "R8 compact op00");
                t_compact(2'b11, 1, 1, 32'h0000_3100, "R8 compact op11 last slot");
                t_reject(1, 2'b01, 0, 0, 4'd3, 2'b01, 5, "R8 compact op01");
                t_reject(1, 2'b10, 0, 0, 4'd3, 2'b01, 5, "R8 compact op10");
                t_reject(1, 2'b11, 1, 0, 4'd3, 2'b01, 5, "R9 inside block");
                t_reject(0, 2'b00, 0, 0, 4'd15, 2'b01, 5, "R7 base pc");
                t_reject(0, 2'b00, 0, 0, 4'd15, 2'b10, 5, "R7 priority over level2");
                t_reject(0, 2'b00, 0, 0, 4'd4, 2'b10, 3, "R5 level2 undef");
                t_reject(0, 2'b00, 0, 0, 4'd4, 2'b00, 4, "R6 level0 nop");
                t_lvl0_undef();
                t_error(1, "R10 first read");
                t_error(2, "R10 second read");
                t_full(1, 0, 32'h0000_5000, 1, 0, 0, "R2 after abort");
            end
            begin
                repeat (100000) @(posedge clk);
                to = 1;
            end
        join_any
        if (to) begin
            errors++;
            $display("FAIL watchdog R11: run hung, actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule